// File: doc/BRIEF.md
# I2C Transmit Abort Cause Tracker

This block sits beside the transmit path of an I2C controller and records why that path was aborted. The master and slave bus engines send it single-cycle event strobes: an unacknowledged address or data byte, a wrongly acknowledged START byte or High Speed code, lost arbitration, a slave read request that finds stale data queued, a software abort request, and so on. It also takes configuration levels: restart enable, 10-bit addressing, High Speed mode, START-byte select, general-call select and master enable. From these it decides which causes apply. Each cause is a sticky bit in a 32-bit status word.

Some causes are linked. A slave that loses arbitration sets both its own bit and the shared arbitration bit. The START-byte-without-restart cause comes back after a clear for as long as its configuration stays wrong. Any cause bit that becomes set raises the abort interrupt and starts a flush of the transmit FIFO. Each command popped during the flush is counted in a saturating field in the top bits of the status word. Software reads the status word directly and clears the cause bits with a one-cycle strobe.

Top module: `txab_tracker`

## Requirements
- R1: While reset is held, and after it is released with no input activity, the status word, the interrupt and the flush request are all zero.
- R2: Single strobes set sticky cause bits that stay set until cleared. 7-bit address not acknowledged sets bit 0. First 10-bit address byte not acknowledged sets bit 1. Second 10-bit address byte not acknowledged sets bit 2. Data byte not acknowledged sets bit 3. General call not acknowledged sets bit 4. High Speed code acknowledged sets bit 6. START byte acknowledged sets bit 7.
- R3: A master arbitration loss sets bit 12 only. A slave arbitration loss sets bit 14 and bit 12 on the same clock edge.
- R4: A slave read request sets bit 13 only if the transmit FIFO level is nonzero. With an empty FIFO it has no effect.
- R5: A command push with `cmd_flags[0]` (the read flag, bit 8 of the command word) set while a slave read is pending sets bit 15. A command push with `cmd_flags[1]` (bit 9 of the command word) set while general call is selected and master mode is enabled sets bit 5.
- R6: A master start while master mode is disabled sets bit 11. With master mode enabled and restart disabled, a master start sets bit 10 if it is a 10-bit read, bit 8 if High Speed mode is selected, and bit 9 if the START-byte select is active.
- R7: An abort request sets bit 16 only while master mode is enabled. Otherwise it is ignored.
- R8: A clear strobe zeroes bits 16:0 on the next edge. A cause that fires on the same edge as the clear is left set. Bits 22:17 always read zero.
- R9: If bit 9 is cleared while restart is disabled and the START-byte select is active, it reads zero for exactly one cycle and is then set again. If that condition is gone, it stays clear.
- R10: The interrupt is high exactly when any of bits 16:0 is set.
- R11: On the edge that sets any previously clear cause bit, the flush request rises. It then stays high while the FIFO level is nonzero and falls on the first edge that sees the level at zero.
- R12: Each FIFO pop seen while the flush request is high increments the count in bits 31:23, which stops at 511. Pops seen with the flush request low do not change the count.
- R13: While the controller-enable input is low the count is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Controller enabled; low zeroes the flush count |
| cfg_master_en | input | 1 | Master mode enabled |
| cfg_restart_en | input | 1 | Repeated-start generation enabled |
| cfg_addr10 | input | 1 | 10-bit addressing selected |
| cfg_hs_mode | input | 1 | High Speed mode selected |
| cfg_special | input | 1 | START-byte transfer selected |
| cfg_gencall | input | 1 | General-call transfer selected |
| abort_req | input | 1 | Software abort request strobe |
| mst_start | input | 1 | Master operation attempt strobe |
| mst_read | input | 1 | The attempted master operation is a read |
| ev_addr7_nack | input | 1 | 7-bit address not acknowledged |
| ev_addr10a_nack | input | 1 | First 10-bit address byte not acknowledged |
| ev_addr10b_nack | input | 1 | Second 10-bit address byte not acknowledged |
| ev_data_nack | input | 1 | Data byte not acknowledged |
| ev_gc_nack | input | 1 | General call not acknowledged |
| ev_sbyte_ack | input | 1 | START byte acknowledged |
| ev_hs_ack | input | 1 | High Speed code acknowledged |
| ev_mst_arblost | input | 1 | Master lost arbitration |
| ev_slv_arblost | input | 1 | Transmitting slave lost the bus |
| ev_slv_rdreq | input | 1 | Read request received in slave mode |
| slv_rd_pending | input | 1 | A slave read request awaits data |
| cmd_push | input | 1 | Software queues a command |
| cmd_flags | input | 2 | [0] read flag, [1] general-call read flag of the queued command |
| fifo_level | input | 8 | Transmit FIFO occupancy |
| fifo_pop | input | 1 | One command removed from the transmit FIFO |
| clr_causes | input | 1 | Clear strobe for bits 16:0 |
| status_word | output | 32 | Count in 31:23, cause bits in 16:0 |
| tx_abort_irq | output | 1 | Transmit-abort interrupt |
| fifo_flush | output | 1 | Flush request to the transmit FIFO |

## Verification
The assertions assume that strobes last one cycle and that the configuration levels are stable around a clear. The bit-9 reassertion checks in particular depend on the restart and START-byte levels keeping their values through the cycle after the clear. The stimulus changes configuration only between strobes. It never issues a START-byte master start on the cycle of a clear, so that the reassertion path can be seen on its own. It keeps the FIFO level nonzero through the long pop run, so the flush stays active while the counter reaches its limit.

// File: rtl/txab_pkg.sv
package txab_pkg;
  localparam int STAT_W  = 32;
  localparam int CAUSE_W = 17;
  localparam int CNT_LSB = 23;

  localparam int B_7B_NACK   = 0;
  localparam int B_10A_NACK  = 1;
  localparam int B_10B_NACK  = 2;
  localparam int B_DATA_NACK = 3;
  localparam int B_GC_NACK   = 4;
  localparam int B_GC_READ   = 5;
  localparam int B_HS_ACK    = 6;
  localparam int B_SB_ACK    = 7;
  localparam int B_HS_NORS   = 8;
  localparam int B_SB_NORS   = 9;
  localparam int B_RD10_NORS = 10;
  localparam int B_MST_DIS   = 11;
  localparam int B_ARB       = 12;
  localparam int B_SLV_FLUSH = 13;
  localparam int B_SLV_ARB   = 14;
  localparam int B_SLV_RDCMD = 15;
  localparam int B_USER      = 16;
endpackage

// File: rtl/txab_cause_decode.sv
module txab_cause_decode
  import txab_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic               cfg_master_en,
  input  logic               cfg_restart_en,
  input  logic               cfg_addr10,
  input  logic               cfg_hs_mode,
  input  logic               cfg_special,
  input  logic               cfg_gencall,
  input  logic               abort_req,
  input  logic               mst_start,
  input  logic               mst_read,
  input  logic               ev_addr7_nack,
  input  logic               ev_addr10a_nack,
  input  logic               ev_addr10b_nack,
  input  logic               ev_data_nack,
  input  logic               ev_gc_nack,
  input  logic               ev_sbyte_ack,
  input  logic               ev_hs_ack,
  input  logic               ev_mst_arblost,
  input  logic               ev_slv_arblost,
  input  logic               ev_slv_rdreq,
  input  logic               slv_rd_pending,
  input  logic               cmd_push,
  input  logic [1:0]         cmd_flags,
  input  logic [LVL_W-1:0]   fifo_level,
  output logic [CAUSE_W-1:0] set_o,
  output logic               hold_sb_o
);
  logic norestart_start;
  logic fifo_nonempty;

  assign norestart_start = mst_start & cfg_master_en & ~cfg_restart_en;
  assign fifo_nonempty   = (fifo_level != '0);
  assign hold_sb_o       = cfg_special & ~cfg_restart_en;

  always_comb begin
    set_o              = '0;
    set_o[B_7B_NACK]   = ev_addr7_nack;
    set_o[B_10A_NACK]  = ev_addr10a_nack;
    set_o[B_10B_NACK]  = ev_addr10b_nack;
    set_o[B_DATA_NACK] = ev_data_nack;
    set_o[B_GC_NACK]   = ev_gc_nack;
    set_o[B_GC_READ]   = cmd_push & cfg_gencall & cfg_master_en & cmd_flags[1];
    set_o[B_HS_ACK]    = ev_hs_ack;
    set_o[B_SB_ACK]    = ev_sbyte_ack;
    set_o[B_HS_NORS]   = norestart_start & cfg_hs_mode;
    set_o[B_SB_NORS]   = norestart_start & cfg_special;
    set_o[B_RD10_NORS] = norestart_start & cfg_addr10 & mst_read;
    set_o[B_MST_DIS]   = mst_start & ~cfg_master_en;
    set_o[B_ARB]       = ev_mst_arblost | ev_slv_arblost;
    set_o[B_SLV_FLUSH] = ev_slv_rdreq & fifo_nonempty;
    set_o[B_SLV_ARB]   = ev_slv_arblost;
    set_o[B_SLV_RDCMD] = cmd_push & slv_rd_pending & cmd_flags[0];
    set_o[B_USER]      = abort_req & cfg_master_en;
  end
endmodule

// File: rtl/txab_cause_reg.sv
module txab_cause_reg
  import txab_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               clr_i,
  input  logic               hold_sb_i,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               new_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] cause_d;
  logic [CAUSE_W-1:0] set_eff;
  logic               pend_q;
  logic               pend_d;

  always_comb begin
    set_eff            = set_i;
    set_eff[B_SB_NORS] = set_i[B_SB_NORS] | (pend_q & hold_sb_i);
  end

  for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
    assign cause_d[i] = (clr_i ? 1'b0 : cause_q[i]) | set_eff[i];
  end

  assign pend_d = clr_i & cause_q[B_SB_NORS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      cause_q <= cause_d;
      pend_q  <= pend_d;
    end
  end

  assign cause_o = cause_q;
  assign new_o   = |(set_eff & ~cause_q);

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q))); // R2
  AST_SLV_ARB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    cause_q[B_SLV_ARB] |-> cause_q[B_ARB]); // R3
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && set_i == '0) |=> (cause_q[CAUSE_W-1:B_SB_NORS+1] == '0 && cause_q[B_SB_NORS-1:0] == '0)); // R8
  AST_SB_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && hold_sb_i) |=> cause_q[B_SB_NORS]); // R9
endmodule

// File: rtl/txab_flush_ctl.sv
module txab_flush_ctl #(
  parameter int LVL_W = 8,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_enable,
  input  logic             new_i,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             fifo_pop,
  output logic             flush_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             flush_q;
  logic             flush_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign flush_d = new_i | (flush_q & (fifo_level != '0));
  assign cnt_en  = ~ctl_enable | (fifo_pop & flush_q & (cnt_q != CNT_MAX));

  always_comb begin
    if (!ctl_enable) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign flush_o = flush_q;
  assign cnt_o   = cnt_q;

  AST_FLUSH_START: assert property (@(posedge clk) disable iff (!rst_n)
    new_i |=> flush_q); // R11
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && ctl_enable) |=> cnt_q == CNT_MAX); // R12
  AST_CNT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> cnt_q == '0); // R13
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && !flush_q) |=> $stable(cnt_q)); // R12
endmodule

// File: rtl/txab_tracker.sv
module txab_tracker
  import txab_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              cfg_master_en,
  input  logic              cfg_restart_en,
  input  logic              cfg_addr10,
  input  logic              cfg_hs_mode,
  input  logic              cfg_special,
  input  logic              cfg_gencall,
  input  logic              abort_req,
  input  logic              mst_start,
  input  logic              mst_read,
  input  logic              ev_addr7_nack,
  input  logic              ev_addr10a_nack,
  input  logic              ev_addr10b_nack,
  input  logic              ev_data_nack,
  input  logic              ev_gc_nack,
  input  logic              ev_sbyte_ack,
  input  logic              ev_hs_ack,
  input  logic              ev_mst_arblost,
  input  logic              ev_slv_arblost,
  input  logic              ev_slv_rdreq,
  input  logic              slv_rd_pending,
  input  logic              cmd_push,
  input  logic [1:0]        cmd_flags,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fifo_pop,
  input  logic              clr_causes,
  output logic [STAT_W-1:0] status_word,
  output logic              tx_abort_irq,
  output logic              fifo_flush
);
  localparam int CNT_W = STAT_W - CNT_LSB;
  localparam int GAP_W = CNT_LSB - CAUSE_W;

  logic [CAUSE_W-1:0] cause_set;
  logic [CAUSE_W-1:0] cause_q;
  logic               hold_sb;
  logic               cause_new;
  logic [CNT_W-1:0]   flush_cnt;

  txab_cause_decode #(.LVL_W(LVL_W)) u_decode (
    .cfg_master_en   (cfg_master_en),
    .cfg_restart_en  (cfg_restart_en),
    .cfg_addr10      (cfg_addr10),
    .cfg_hs_mode     (cfg_hs_mode),
    .cfg_special     (cfg_special),
    .cfg_gencall     (cfg_gencall),
    .abort_req       (abort_req),
    .mst_start       (mst_start),
    .mst_read        (mst_read),
    .ev_addr7_nack   (ev_addr7_nack),
    .ev_addr10a_nack (ev_addr10a_nack),
    .ev_addr10b_nack (ev_addr10b_nack),
    .ev_data_nack    (ev_data_nack),
    .ev_gc_nack      (ev_gc_nack),
    .ev_sbyte_ack    (ev_sbyte_ack),
    .ev_hs_ack       (ev_hs_ack),
    .ev_mst_arblost  (ev_mst_arblost),
    .ev_slv_arblost  (ev_slv_arblost),
    .ev_slv_rdreq    (ev_slv_rdreq),
    .slv_rd_pending  (slv_rd_pending),
    .cmd_push        (cmd_push),
    .cmd_flags       (cmd_flags),
    .fifo_level      (fifo_level),
    .set_o           (cause_set),
    .hold_sb_o       (hold_sb)
  );

  txab_cause_reg u_causes (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (cause_set),
    .clr_i     (clr_causes),
    .hold_sb_i (hold_sb),
    .cause_o   (cause_q),
    .new_o     (cause_new)
  );

  txab_flush_ctl #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_flush (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_enable (ctl_enable),
    .new_i      (cause_new),
    .fifo_level (fifo_level),
    .fifo_pop   (fifo_pop),
    .flush_o    (fifo_flush),
    .cnt_o      (flush_cnt)
  );

  assign status_word  = {flush_cnt, {GAP_W{1'b0}}, cause_q};
  assign tx_abort_irq = |cause_q;

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_abort_irq) |-> $past(cause_set != '0 || hold_sb)); // R10
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[CNT_LSB-1:CAUSE_W] == '0); // R8
endmodule

// File: tb/txab_tracker_bench.sv
`timescale 1ns/1ps
module txab_tracker_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_enable, cfg_master_en, cfg_restart_en, cfg_addr10, cfg_hs_mode;
  logic cfg_special, cfg_gencall, abort_req, mst_start, mst_read;
  logic ev_addr7_nack, ev_addr10a_nack, ev_addr10b_nack, ev_data_nack, ev_gc_nack;
  logic ev_sbyte_ack, ev_hs_ack, ev_mst_arblost, ev_slv_arblost, ev_slv_rdreq;
  logic slv_rd_pending, cmd_push, fifo_pop, clr_causes;
  logic [1:0]  cmd_flags;
  logic [7:0]  fifo_level;
  logic [31:0] status_word;
  logic        tx_abort_irq, fifo_flush;

  always #2.5 clk = ~clk;

  txab_tracker u_txab_tracker (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .cfg_master_en(cfg_master_en),
    .cfg_restart_en(cfg_restart_en), .cfg_addr10(cfg_addr10), .cfg_hs_mode(cfg_hs_mode),
    .cfg_special(cfg_special), .cfg_gencall(cfg_gencall), .abort_req(abort_req),
    .mst_start(mst_start), .mst_read(mst_read), .ev_addr7_nack(ev_addr7_nack),
    .ev_addr10a_nack(ev_addr10a_nack), .ev_addr10b_nack(ev_addr10b_nack),
    .ev_data_nack(ev_data_nack), .ev_gc_nack(ev_gc_nack), .ev_sbyte_ack(ev_sbyte_ack),
    .ev_hs_ack(ev_hs_ack), .ev_mst_arblost(ev_mst_arblost), .ev_slv_arblost(ev_slv_arblost),
    .ev_slv_rdreq(ev_slv_rdreq), .slv_rd_pending(slv_rd_pending), .cmd_push(cmd_push),
    .cmd_flags(cmd_flags), .fifo_level(fifo_level), .fifo_pop(fifo_pop),
    .clr_causes(clr_causes), .status_word(status_word), .tx_abort_irq(tx_abort_irq),
    .fifo_flush(fifo_flush)
  );

  typedef struct {
    logic [31:0] st;
    logic        irq;
    logic        fl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec  = 0;
  int   n_fail = 0;

  logic [16:0] m_st;
  logic [8:0]  m_cnt;
  logic        m_fl;
  logic        m_pend;

  task automatic clear_strobes();
    abort_req = 0; mst_start = 0; ev_addr7_nack = 0; ev_addr10a_nack = 0;
    ev_addr10b_nack = 0; ev_data_nack = 0; ev_gc_nack = 0; ev_sbyte_ack = 0;
    ev_hs_ack = 0; ev_mst_arblost = 0; ev_slv_arblost = 0; ev_slv_rdreq = 0;
    cmd_push = 0; fifo_pop = 0; clr_causes = 0;
  endtask

  function automatic logic [16:0] req_set();
    logic [16:0] s;
    logic        nr;
    s = '0;
    nr = mst_start && cfg_master_en && !cfg_restart_en;
    s[0]  = ev_addr7_nack;
    s[1]  = ev_addr10a_nack;
    s[2]  = ev_addr10b_nack;
    s[3]  = ev_data_nack;
    s[4]  = ev_gc_nack;
    s[5]  = cmd_push && cfg_gencall && cfg_master_en && cmd_flags[1];
    s[6]  = ev_hs_ack;
    s[7]  = ev_sbyte_ack;
    s[8]  = nr && cfg_hs_mode;
    s[9]  = nr && cfg_special;
    s[10] = nr && cfg_addr10 && mst_read;
    s[11] = mst_start && !cfg_master_en;
    s[12] = ev_mst_arblost || ev_slv_arblost;
    s[13] = ev_slv_rdreq && (fifo_level != 0);
    s[14] = ev_slv_arblost;
    s[15] = cmd_push && slv_rd_pending && cmd_flags[0];
    s[16] = abort_req && cfg_master_en;
    return s;
  endfunction

  // driver: applies the current inputs for one edge and queues the expectation
  task automatic step(input string tag);
    logic [16:0] s, nw, nst;
    logic [8:0]  ncnt;
    logic        nfl, npend;
    s = req_set();
    if (m_pend && cfg_special && !cfg_restart_en) s[9] = 1'b1;
    nw    = s & ~m_st;
    nst   = (clr_causes ? 17'd0 : m_st) | s;
    npend = clr_causes && m_st[9];
    nfl   = (nw != 0) || (m_fl && fifo_level != 0);
    if (!ctl_enable) ncnt = 0;
    else if (fifo_pop && m_fl && m_cnt != 9'd511) ncnt = m_cnt + 1;
    else ncnt = m_cnt;
    @(posedge clk);
    #1;
    m_st = nst; m_cnt = ncnt; m_fl = nfl; m_pend = npend;
    exp_q.push_back('{st: {m_cnt, 6'b0, m_st}, irq: (m_st != 0), fl: m_fl, tag: tag});
    clear_strobes();
  endtask

  // monitor: compares the design outputs against the queued expectations
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (status_word !== e.st || tx_abort_irq !== e.irq || fifo_flush !== e.fl) begin
        n_fail++;
        $display("FAIL %s: status %h irq %b flush %b, expected status %h irq %b flush %b",
                 e.tag, status_word, tx_abort_irq, fifo_flush, e.st, e.irq, e.fl);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    ctl_enable = 1; cfg_master_en = 1; cfg_restart_en = 1; cfg_addr10 = 0;
    cfg_hs_mode = 0; cfg_special = 0; cfg_gencall = 0; mst_read = 0;
    slv_rd_pending = 0; cmd_flags = 2'b00; fifo_level = 0;
    clear_strobes();
    m_st = 0; m_cnt = 0; m_fl = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (status_word !== 32'd0 || tx_abort_irq !== 1'b0 || fifo_flush !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: status %h irq %b flush %b during reset, expected 0 0 0",
               status_word, tx_abort_irq, fifo_flush);
    end
    rst_n = 1;
    step("R1 idle after reset");

    ev_addr7_nack = 1;    step("R2 7-bit address nack");
    step("R2 sticky, R11 flush drops with empty FIFO");
    ev_addr10a_nack = 1; ev_data_nack = 1; step("R2 10-bit first byte and data nack");
    ev_addr10b_nack = 1; ev_gc_nack = 1; step("R2 second byte and general call nack");
    ev_sbyte_ack = 1; ev_hs_ack = 1; step("R2 START byte and HS code acked, R10");
    clr_causes = 1; step("R8 clear zeroes causes");
    step("R10 irq low after clear");

    ev_mst_arblost = 1; step("R3 master arbitration lost alone");
    clr_causes = 1; step("R8 clear");
    ev_slv_arblost = 1; step("R3 slave arbitration lost pairs with bit 12");
    clr_causes = 1; step("R8 clear");

    ev_slv_rdreq = 1; step("R4 slave read request with empty FIFO ignored");
    fifo_level = 2;
    ev_slv_rdreq = 1; step("R4 slave read request with queued data");
    step("R11 flush held while FIFO nonempty");
    fifo_pop = 1; step("R12 pop during flush counts");
    fifo_level = 0; step("R11 flush falls at empty level");
    fifo_pop = 1; step("R12 pop outside flush ignored");
    clr_causes = 1; step("R8 clear");

    slv_rd_pending = 1; cmd_flags = 2'b01; cmd_push = 1; step("R5 read-flag command for slave read");
    slv_rd_pending = 0; cfg_gencall = 1; cmd_flags = 2'b10; cmd_push = 1;
    step("R5 general call followed by read");
    cfg_gencall = 0; cmd_flags = 2'b00; clr_causes = 1; step("R8 clear");

    cfg_master_en = 0; mst_start = 1; step("R6 master start with master disabled");
    abort_req = 1; step("R7 abort request ignored with master disabled");
    cfg_master_en = 1; abort_req = 1; step("R7 abort request with master enabled");
    clr_causes = 1; step("R8 clear");
    cfg_restart_en = 0; cfg_addr10 = 1; mst_read = 1; mst_start = 1; step("R6 10-bit read without restart");
    cfg_addr10 = 0; mst_read = 0; cfg_hs_mode = 1; mst_start = 1; step("R6 HS without restart");
    cfg_hs_mode = 0; cfg_special = 1; mst_start = 1; step("R6 START byte without restart");
    clr_causes = 1; step("R9 bit 9 drops for one cycle");
    step("R9 bit 9 reasserted");
    step("R9 bit 9 stays set");
    cfg_special = 0; clr_causes = 1; step("R9 clear with condition gone");
    step("R9 bit 9 stays clear");
    step("R9 bit 9 still clear");
    cfg_restart_en = 1;

    ev_data_nack = 1; clr_causes = 1; step("R8 cause on clear edge stays set");
    ev_data_nack = 1; step("R11 no new flush for already set cause");

    fifo_level = 5; clr_causes = 1; step("R8 clear before flush run");
    ev_gc_nack = 1; step("R11 new cause starts flush");
    for (int k = 0; k < 520; k++) begin
      fifo_pop = 1;
      step("R12 counting pops to saturation");
    end
    fifo_pop = 1; step("R12 count holds at 511");
    ctl_enable = 0; step("R13 disable zeroes count");
    fifo_pop = 1; step("R13 count held at zero while disabled");
    ctl_enable = 1; fifo_pop = 1; step("R12 counting resumes after enable");

    repeat (3) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule